// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Port Formatter

This block turns a stream of 4:2:2 video pixels into the signals of a 16-bit output pixel port and its line-locked clocks. Each pixel carries one luma byte and one chroma byte. Even pixels carry Cb and odd pixels carry Cr. Each pixel is held for two cycles of the full-rate clock `clk_i`. A free-running four-slot counter splits time into sample pairs. A start-of-line strobe realigns that counter. The pair is the unit that is buffered, reordered and emitted.

Two bus formats are supported. The narrow format puts Cb, Y, Cr and Y bytes in turn on the upper byte lane, one byte per full-rate cycle, and releases the lower lane. The wide format puts luma on the upper lane and chroma on the lower lane. Each lane word is held for two full-rate cycles, so data moves at the half rate. A swap bit exchanges the places of Cb and Cr. The format and swap settings are sampled only on a line start, so a line is always emitted with a single setting. A half-rate clock is produced alongside the data. A clock-pad select chooses whether the primary clock pin carries the full-rate clock or the half-rate clock. A polarity input inverts both clock pins.

Top module: `pix_port_fmt`

## Requirements
- R1: While reset is held, `data_o` and `data_oe_o` are all zero, `cfg_err_o` is 0 and `llc2_o` equals `1 ^ pol_i`. After reset the active format is 0011 and the swap bit is 0.
- R2: The slot counter steps 0,1,2,3,0,… on each full-rate cycle. A cycle with `sol_i` high is slot 0. The pixel present in slot 0 is captured as the first pixel of a pair (Y0, Cb), and the pixel in slot 2 is captured as the second (Y1, Cr). A pair whose slot-0 cycle is cycle t drives byte index k (k = 0..3) on the bus during cycle t+5+k.
- R3: With format 0011, `data_o[15:8]` carries the first chroma, Y0, the second chroma and Y1 at byte indices 0..3. `data_o[7:0]` is 0 and `data_oe_o` is 16'hFF00.
- R4: With format 0010, `data_o[15:8]` carries Y0 at indices 0–1 and Y1 at indices 2–3. `data_o[7:0]` carries the first chroma at indices 0–1 and the second chroma at indices 2–3. `data_oe_o` is 16'hFFFF.
- R5: With swap 0 the first chroma is Cb and the second is Cr. With swap 1 the order is reversed, in both formats.
- R6: `fmt_sel_i` and `swap_i` are sampled only in a cycle with `sol_i` high. The sampled values govern every pair captured after that line start, and changes at other times have no effect.
- R7: Any format value other than 0010 and 0011, the reserved range 0110–1111 included, drives `data_o` and `data_oe_o` to zero and raises `cfg_err_o` for the cycles of the affected pairs.
- R8: If either pixel of a pair has `vld_i` low in its capture slot, the pair is emitted as blanking: luma 8'h10 and chroma 8'h80, in the active format.
- R9: `llc2_o` is high while an odd byte index (luma in the narrow format) is on the bus, XOR `pol_i`. Without `sol_i` it toggles every full-rate cycle.
- R10: `cks_sel_i` = 000 gives `llc1_o = clk_i ^ pol_i`, and 101 gives `llc1_o = llc2_o`. Any other value holds `llc1_o` at 0 and raises `cfg_err_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sol_i | input | 1 | Start of line, high in the first cycle of pixel 0 |
| vld_i | input | 1 | Pixel valid |
| y_i | input | 8 | Luma byte of current pixel |
| c_i | input | 8 | Chroma byte of current pixel (Cb even, Cr odd) |
| fmt_sel_i | input | 4 | Bus format select |
| swap_i | input | 1 | Exchange Cb and Cr order |
| cks_sel_i | input | 3 | Primary clock pin source select |
| pol_i | input | 1 | Clock polarity invert |
| data_o | output | 16 | Pixel port data |
| data_oe_o | output | 16 | Per-bit output enable (0 = high impedance) |
| llc1_o | output | 1 | Primary line-locked clock |
| llc2_o | output | 1 | Half-rate line-locked clock |
| cfg_err_o | output | 1 | Unsupported format or clock select in use |

## Verification
The bench changes format and swap in the middle of a line. A design that applies such a change at once would mix two chroma orders or two bus widths within one line. Line starts are placed at odd gaps so that the slot counter must realign. A design that free-runs through a line start would emit chroma bytes where luma belongs and would put the half-rate clock out of phase. Invalid pixels, reserved format codes and reserved clock selects are each driven on their own. A design that fails there would leak stale bytes onto the bus, leave the bus enabled, or never raise the error flag. The narrow and wide formats are each run with and without swap, and with the polarity inverted, to catch a wrong byte order or an inverted clock edge.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
  localparam int unsigned BW    = 8;
  localparam int unsigned SLOTS = 4;
  localparam int unsigned SW    = $clog2(SLOTS);
  localparam int unsigned NL    = 2;

  localparam logic [3:0] FMT_WIDE   = 4'b0010;
  localparam logic [3:0] FMT_NARROW = 4'b0011;
  localparam logic [2:0] CKS_FULL   = 3'b000;
  localparam logic [2:0] CKS_HALF   = 3'b101;

  localparam logic [BW-1:0] BLANK_Y = 8'h10;
  localparam logic [BW-1:0] BLANK_C = 8'h80;

  typedef struct packed {
    logic [3:0]    fmt;
    logic          swap;
    logic          vld;
    logic [BW-1:0] y0;
    logic [BW-1:0] y1;
    logic [BW-1:0] cb;
    logic [BW-1:0] cr;
  } pair_t;

  function automatic logic fmt_ok(input logic [3:0] f);
    return (f == FMT_WIDE) || (f == FMT_NARROW);
  endfunction

  function automatic logic cks_ok(input logic [2:0] s);
    return (s == CKS_FULL) || (s == CKS_HALF);
  endfunction
endpackage

// File: rtl/pix_slot_ctr.sv
module pix_slot_ctr
  import pix_fmt_pkg::*;
#(
  parameter int unsigned N = SLOTS,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sol_i,
  output logic [W-1:0] slot_o
);
  logic [W-1:0] slot_q;

  // slot of the current cycle; line start forces 0
  always_comb begin
    if (sol_i)                     slot_o = '0;
    else if (slot_q == W'(N - 1))  slot_o = '0;
    else                           slot_o = slot_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= W'(N - 1);
    else         slot_q <= slot_o;
  end

  p_sol_realign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_i |=> (slot_q == '0));
endmodule

// File: rtl/pix_pair_cap.sv
module pix_pair_cap
  import pix_fmt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sol_i,
  input  logic [SW-1:0] slot_i,
  input  logic [BW-1:0] y_i,
  input  logic [BW-1:0] c_i,
  input  logic          vld_i,
  input  logic [3:0]    fmt_i,
  input  logic          swap_i,
  output pair_t         pair_o
);
  logic [3:0] act_fmt_q;
  logic       act_swap_q;
  pair_t      pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_fmt_q  <= FMT_NARROW;
      act_swap_q <= 1'b0;
    end else if (sol_i) begin
      act_fmt_q  <= fmt_i;
      act_swap_q <= swap_i;
    end
  end

  // one capture stage per pixel of the pair, at slots 0 and 2
  for (genvar g = 0; g < 2; g++) begin : g_cap
    logic [BW-1:0] y_q;
    logic [BW-1:0] c_q;
    logic          v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        y_q <= '0;
        c_q <= '0;
        v_q <= 1'b0;
      end else if (slot_i == SW'(2 * g)) begin
        y_q <= y_i;
        c_q <= c_i;
        v_q <= vld_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q      <= '0;
      pair_q.fmt  <= FMT_NARROW;
    end else if (slot_i == SW'(SLOTS - 1)) begin
      pair_q.fmt  <= act_fmt_q;
      pair_q.swap <= act_swap_q;
      pair_q.vld  <= g_cap[0].v_q & g_cap[1].v_q;
      pair_q.y0   <= g_cap[0].y_q;
      pair_q.cb   <= g_cap[0].c_q;
      pair_q.y1   <= g_cap[1].y_q;
      pair_q.cr   <= g_cap[1].c_q;
    end
  end

  assign pair_o = pair_q;

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sol_i |=> ($stable(act_fmt_q) && $stable(act_swap_q)));
endmodule

// File: rtl/pix_lane_mux.sv
module pix_lane_mux
  import pix_fmt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pair_t            pair_i,
  input  logic [SW-1:0]    slot_i,
  input  logic [2:0]       cks_i,
  output logic [NL*BW-1:0] data_o,
  output logic [NL*BW-1:0] oe_o,
  output logic             err_o
);
  localparam int unsigned DW = NL * BW;

  logic [BW-1:0] y0, y1, c_a, c_b;
  logic          narrow, wide, late;
  logic [BW-1:0] lane_d  [NL];
  logic          lane_en [NL];
  logic [DW-1:0] data_d, oe_d;

  logic [DW-1:0] data_q, oe_q;
  logic          err_q, wide_q;
  logic [SW-1:0] idx_q;

  always_comb begin
    y0  = pair_i.vld ? pair_i.y0 : BLANK_Y;
    y1  = pair_i.vld ? pair_i.y1 : BLANK_Y;
    c_a = pair_i.vld ? (pair_i.swap ? pair_i.cr : pair_i.cb) : BLANK_C;
    c_b = pair_i.vld ? (pair_i.swap ? pair_i.cb : pair_i.cr) : BLANK_C;
    narrow = (pair_i.fmt == FMT_NARROW);
    wide   = (pair_i.fmt == FMT_WIDE);
    late   = slot_i[SW-1];
  end

  // lane NL-1 is the upper byte, lane 0 the lower
  for (genvar l = 0; l < NL; l++) begin : g_lane
    if (l == NL - 1) begin : g_hi
      always_comb begin
        lane_en[l] = narrow | wide;
        if (narrow)
          lane_d[l] = slot_i[0] ? (late ? y1 : y0) : (late ? c_b : c_a);
        else if (wide)
          lane_d[l] = late ? y1 : y0;
        else
          lane_d[l] = '0;
      end
    end else begin : g_lo
      always_comb begin
        lane_en[l] = wide;
        lane_d[l]  = wide ? (late ? c_b : c_a) : '0;
      end
    end
    assign data_d[l*BW +: BW] = lane_d[l];
    assign oe_d[l*BW +: BW]   = {BW{lane_en[l]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= '0;
      err_q  <= 1'b0;
      wide_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      data_q <= data_d;
      oe_q   <= oe_d;
      err_q  <= !fmt_ok(pair_i.fmt) || !cks_ok(cks_i);
      wide_q <= wide;
      idx_q  <= slot_i;
    end
  end

  assign data_o = data_q;
  assign oe_o   = oe_q;
  assign err_o  = err_q;

  p_oe_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q == '0) || (oe_q == {DW{1'b1}}) || (oe_q == {{BW{1'b1}}, {(DW-BW){1'b0}}}));

  p_wide_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_q && idx_q[0]) |-> $stable(data_q));
endmodule

// File: rtl/pix_clk_out.sv
module pix_clk_out
  import pix_fmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sol_i,
  input  logic       odd_i,
  input  logic       pol_i,
  input  logic [2:0] cks_i,
  output logic       llc1_o,
  output logic       llc2_o
);
  logic llc2_q;

  // divide-by-2 phase-locked to the byte index; high over luma bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) llc2_q <= 1'b1;
    else         llc2_q <= odd_i;
  end

  assign llc2_o = llc2_q ^ pol_i;

  always_comb begin
    unique case (cks_i)
      CKS_FULL: llc1_o = clk_i ^ pol_i;
      CKS_HALF: llc1_o = llc2_o;
      default:  llc1_o = 1'b0;
    endcase
  end

  p_half_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sol_i |=> (llc2_q != $past(llc2_q)));
endmodule

// File: rtl/pix_port_fmt.sv
module pix_port_fmt
  import pix_fmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sol_i,
  input  logic        vld_i,
  input  logic [7:0]  y_i,
  input  logic [7:0]  c_i,
  input  logic [3:0]  fmt_sel_i,
  input  logic        swap_i,
  input  logic [2:0]  cks_sel_i,
  input  logic        pol_i,
  output logic [15:0] data_o,
  output logic [15:0] data_oe_o,
  output logic        llc1_o,
  output logic        llc2_o,
  output logic        cfg_err_o
);
  logic [SW-1:0] slot;
  pair_t         pair;

  pix_slot_ctr #(.N(SLOTS)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sol_i  (sol_i),
    .slot_o (slot)
  );

  pix_pair_cap u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sol_i  (sol_i),
    .slot_i (slot),
    .y_i    (y_i),
    .c_i    (c_i),
    .vld_i  (vld_i),
    .fmt_i  (fmt_sel_i),
    .swap_i (swap_i),
    .pair_o (pair)
  );

  pix_lane_mux u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pair_i (pair),
    .slot_i (slot),
    .cks_i  (cks_sel_i),
    .data_o (data_o),
    .oe_o   (data_oe_o),
    .err_o  (cfg_err_o)
  );

  pix_clk_out u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sol_i  (sol_i),
    .odd_i  (slot[0]),
    .pol_i  (pol_i),
    .cks_i  (cks_sel_i),
    .llc1_o (llc1_o),
    .llc2_o (llc2_o)
  );

  p_hiz_bad_fmt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && $past(cks_ok(cks_sel_i))) |-> (data_oe_o == '0 && data_o == '0));
endmodule

// File: tb/pix_port_fmt_test.sv
module pix_port_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sol = 1'b0, vld = 1'b0;
  logic [7:0]  y = '0, c = '0;
  logic [3:0]  fmt = 4'b0011;
  logic        swap = 1'b0;
  logic [2:0]  cks = 3'b000;
  logic        pol = 1'b0;
  logic [15:0] data, oe;
  logic        llc1, llc2, err;

  always #10 clk = ~clk;

  pix_port_fmt uut (
    .clk_i(clk), .rst_ni(rst_n), .sol_i(sol), .vld_i(vld), .y_i(y), .c_i(c),
    .fmt_sel_i(fmt), .swap_i(swap), .cks_sel_i(cks), .pol_i(pol),
    .data_o(data), .data_oe_o(oe), .llc1_o(llc1), .llc2_o(llc2), .cfg_err_o(err)
  );

  int n_cmp = 0, n_bad = 0;
  bit chk_en = 1'b0;
  string scen = "R2";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_slot;
  int cy[2], cc[2], cv[2];
  int p_y0, p_y1, p_cb, p_cr, p_v, p_fmt, p_swap;
  int a_fmt, a_swap;
  int e_data, e_oe, e_err, e_l2;
  string e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot = 3; a_fmt = 3; a_swap = 0;
      p_y0 = 0; p_y1 = 0; p_cb = 0; p_cr = 0; p_v = 0; p_fmt = 3; p_swap = 0;
      for (int i = 0; i < 2; i++) begin cy[i] = 0; cc[i] = 0; cv[i] = 0; end
      e_data = 0; e_oe = 0; e_err = 0; e_l2 = 1; e_tag = "R1";
    end else begin
      int cur, ya, yb, ca, cb2, bt;
      cur = sol ? 0 : (m_slot + 1) % 4;
      ya = p_v ? p_y0 : 'h10;
      yb = p_v ? p_y1 : 'h10;
      ca = p_v ? (p_swap ? p_cr : p_cb) : 'h80;
      cb2 = p_v ? (p_swap ? p_cb : p_cr) : 'h80;
      if (p_fmt == 3) begin
        case (cur)
          0: bt = ca; 1: bt = ya; 2: bt = cb2; default: bt = yb;
        endcase
        e_data = bt << 8; e_oe = 'hFF00; e_tag = "R3";
      end else if (p_fmt == 2) begin
        e_data = ((cur < 2 ? ya : yb) << 8) | (cur < 2 ? ca : cb2);
        e_oe = 'hFFFF; e_tag = "R4";
      end else begin
        e_data = 0; e_oe = 0; e_tag = "R7";
      end
      if (!p_v) e_tag = "R8";
      e_err = ((p_fmt != 2 && p_fmt != 3) || (cks != 0 && cks != 5)) ? 1 : 0;
      e_l2 = cur % 2;
      if (sol) begin a_fmt = fmt; a_swap = swap; end
      if (cur == 0 || cur == 2) begin
        cy[cur/2] = y; cc[cur/2] = c; cv[cur/2] = vld;
      end
      if (cur == 3) begin
        p_y0 = cy[0]; p_cb = cc[0]; p_y1 = cy[1]; p_cr = cc[1];
        p_v = cv[0] & cv[1]; p_fmt = a_fmt; p_swap = a_swap;
      end
      m_slot = cur;
    end
  end

  always @(posedge clk) begin
    if (chk_en && rst_n) begin
      int l2, l1;
      #5;
      l2 = e_l2 ^ pol;
      l1 = (cks == 0) ? (1 ^ pol) : (cks == 5) ? l2 : 0;
      chk({scen, " ", e_tag}, "data", int'(data), e_data);
      chk({scen, " ", e_tag}, "oe", int'(oe), e_oe);
      chk({scen, " R7 R10"}, "err", int'(err), e_err);
      chk({scen, " R9"}, "llc2", int'(llc2), l2);
      chk({scen, " R10"}, "llc1", int'(llc1), l1);
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      sol = 1'b0; vld = 1'b0;
    end
  endtask

  task automatic line(input int npix, input int base, input int mid_pix,
                      input logic [3:0] mid_fmt, input logic mid_swap, input int bad_pix);
    for (int p = 0; p < npix; p++) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        sol = (p == 0 && k == 0);
        vld = (p != bad_pix);
        y = 8'(base + p * 5);
        c = (p % 2 == 0) ? 8'(base + 'h40 + p) : 8'(base + 'h90 + p);
        if (p == mid_pix && k == 0) begin fmt = mid_fmt; swap = mid_swap; end
      end
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "data", int'(data), 0);
    chk("R1", "oe", int'(oe), 0);
    chk("R1", "err", int'(err), 0);
    chk("R1", "llc2", int'(llc2), 1);
    @(negedge clk); rst_n = 1'b1; chk_en = 1'b1;
    idle(6);
    scen = "R2"; line(8, 'h20, -1, 4'd3, 1'b0, -1); idle(7);
    scen = "R5"; swap = 1'b1; line(8, 'h31, -1, 4'd3, 1'b1, -1); idle(5);
    scen = "R4"; fmt = 4'b0010; swap = 1'b0; line(8, 'h12, -1, 4'd2, 1'b0, -1); idle(6);
    scen = "R4 R5"; swap = 1'b1; line(6, 'h55, -1, 4'd2, 1'b1, -1); idle(9);
    // R6: mid-line change must wait for the next line start
    scen = "R6"; fmt = 4'b0011; swap = 1'b0;
    line(8, 'h66, 3, 4'b0010, 1'b1, -1);
    line(8, 'h70, -1, 4'b0010, 1'b1, -1); idle(6);
    scen = "R8"; fmt = 4'b0011; swap = 1'b0; line(8, 'h44, -1, 4'd3, 1'b0, 2); idle(6);
    scen = "R7"; fmt = 4'b0111; line(4, 'h01, -1, 4'b0111, 1'b0, -1);
    fmt = 4'b0000; line(4, 'h02, -1, 4'b0000, 1'b0, -1);
    fmt = 4'b1111; line(4, 'h03, -1, 4'b1111, 1'b0, -1); idle(6);
    scen = "R9 R10"; fmt = 4'b0011; cks = 3'b101; pol = 1'b1; line(6, 'h21, -1, 4'd3, 1'b0, -1);
    cks = 3'b011; line(6, 'h22, -1, 4'd3, 1'b0, -1);
    cks = 3'b000; line(6, 'h23, -1, 4'd3, 1'b0, -1);
    pol = 1'b0; fmt = 4'b0010; cks = 3'b101; line(6, 'h24, -1, 4'd2, 1'b0, -1);
    idle(8);
    chk_en = 1'b0;
    summary();
    $finish;
  end
endmodule